// File: doc/BRIEF.md
# Bulk OUT Receive Sequencer

This block sits between the packet receiver of a bulk OUT endpoint and a FIFO that supports mark and rewind. Bytes of one data packet arrive on a valid-qualified byte stream. Each byte lands in a two-entry staging buffer. The buffer empties toward the FIFO write port whenever it holds data and the FIFO reports that it can take a write. When the packet ends, the block waits until every staged byte has left. It then issues exactly one handshake decision for the packet.

The decision is ACK only if three things hold. Exactly `MAX_PKT` bytes were received. No receive error was flagged. Every byte reached the FIFO without overflowing it. An ACK comes with a one-cycle mark strobe, which commits the packet in the FIFO. Any other outcome gives a NACK with a one-cycle rewind strobe, which discards what the packet wrote. An error is held from the moment it is seen until the decision. It is cleared when the next packet starts.

Top module: `bulk_out_rx_seq`

## Requirements
- R1: After synchronous reset, `fifo_wr_en`, `hs_valid`, `hs_ack`, `fifo_mark` and `fifo_rewind` are all low.
- R2: With no error and `fifo_wr_rdy` high, every received byte is written to the FIFO once, in arrival order.
- R3: No FIFO write is issued in a cycle in which `fifo_wr_rdy` was low. Up to two bytes wait in the staging buffer and are written later in order.
- R4: A packet of exactly `MAX_PKT` (default 64) bytes with no error ends in one `hs_valid` pulse with `hs_ack`=1 (ACK), one `fifo_mark` pulse and no `fifo_rewind`.
- R5: A packet of fewer or more than `MAX_PKT` bytes, including an end-of-packet with no data, ends in NACK (`hs_ack`=0) with one `fifo_rewind` pulse and no `fifo_mark`.
- R6: `rx_err` high with any byte of a packet, or at its end-of-packet, forces NACK with rewind.
- R7: A byte that arrives while both buffer entries are full and no write leaves is dropped, never written, and forces NACK with rewind.
- R8: `fifo_ovr` high in a cycle in which `fifo_wr_en` is high (the FIFO refused that write) forces NACK with rewind.
- R9: The handshake comes only after end-of-packet, once the buffer is empty and no write is in flight. `hs_valid` is never high together with `fifo_wr_en`.
- R10: `fifo_mark` and `fifo_rewind` are single-cycle pulses. Exactly one of them is high in the cycle `hs_valid` is high, and neither is high in any other cycle. `hs_ack` equals `fifo_mark`.
- R11: An error latched in one packet does not carry over. The next error-free packet of `MAX_PKT` bytes gets ACK.
- R12: `rx_valid` bytes that arrive after end-of-packet, before the handshake, are ignored: they are not written and do not change the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of packet (may coincide with the last byte) |
| rx_err | input | 1 | Receive error flag for this cycle |
| fifo_wr_rdy | input | 1 | FIFO can take a write this cycle |
| fifo_ovr | input | 1 | FIFO refused the write presented this cycle |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | FIFO write byte |
| fifo_mark | output | 1 | Commit packet in FIFO (with ACK) |
| fifo_rewind | output | 1 | Roll back packet in FIFO (with NACK) |
| hs_valid | output | 1 | Handshake decision valid (one cycle) |
| hs_ack | output | 1 | 1 = ACK, 0 = NACK, valid with `hs_valid` |

## Verification
Every cycle, the assertions check four things. No write follows a cycle without `fifo_wr_rdy`. The handshake never overlaps a write and always finds the buffer empty. Mark and rewind are exclusive pulses tied to `hs_valid`, and an ACK always carries the exact byte count. The buffer occupancy never exceeds two, and no write happens while the sequencer is idle. Only the bench's scenarios can show the decision itself for each cause: short, long or empty packets, error flags, dropped bytes, refused writes. They also show the byte order written to the FIFO, the clearing of errors between packets, and that late bytes are ignored while the drain is held off.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HS    = 2'd3
  } bor_state_t;

endpackage

// File: rtl/bor_rx_buffer.sv
module bor_rx_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          drain_rdy,
  output logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          overrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] count;
  logic          full;
  logic          accept;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop     = !empty && drain_rdy;
  assign accept  = push && (!full || pop);
  assign overrun = push && full && !pop;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  // storage without reset so it maps onto plain RAM/registers
  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= nxt(wptr);
      if (pop)    rptr <= nxt(rptr);
      case ({accept, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_drop_holds_full_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/bor_wr_stage.sv
module bor_wr_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] take_data,
  input  logic          wr_rdy,
  input  logic          ovr_in,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          ovr_hit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= take;
      if (take) wr_data <= take_data;
    end
  end

  assign ovr_hit = wr_en && ovr_in;

  p_wr_needs_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(wr_rdy));

endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
  import bor_pkg::*;
#(
  parameter int MAX_PKT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_eop,
  input  logic       rx_err,
  input  logic       buf_empty,
  input  logic       buf_ovr,
  input  logic       wr_busy,
  input  logic       ovr_hit,
  output logic       push_en,
  output bor_state_t st,
  output logic       hs_valid,
  output logic       hs_ack,
  output logic       mark,
  output logic       rewind
);

  localparam int CW = $clog2(MAX_PKT + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(MAX_PKT);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MAX_PKT + 1);

  logic [CW-1:0] cnt;
  logic          err;
  logic          drained;
  logic          pass;

  assign push_en = rx_valid && ((st == ST_IDLE) || (st == ST_RECV));
  assign drained = buf_empty && !wr_busy;
  assign pass    = !err && (cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      err      <= 1'b0;
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
      mark     <= 1'b0;
      rewind   <= 1'b0;
    end else begin
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
      mark     <= 1'b0;
      rewind   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rx_valid || rx_eop) begin
            cnt <= rx_valid ? CW'(1) : '0;
            err <= rx_err;
            st  <= rx_eop ? ST_DRAIN : ST_RECV;
          end
        end
        ST_RECV: begin
          if (rx_valid && (cnt != CNT_SAT)) cnt <= cnt + CW'(1);
          if (rx_err || buf_ovr || ovr_hit) err <= 1'b1;
          if (rx_eop) st <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (ovr_hit) err <= 1'b1;
          if (drained) begin
            st       <= ST_HS;
            hs_valid <= 1'b1;
            hs_ack   <= pass;
            mark     <= pass;
            rewind   <= !pass;
          end
        end
        default: begin
          st <= ST_IDLE;
        end
      endcase
    end
  end

  p_hs_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    hs_valid |=> !hs_valid);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> ($countones({mark, rewind}) == 1));

  p_strobe_needs_hs_r10: assert property (@(posedge clk) disable iff (rst)
    (mark || rewind) |-> hs_valid);

  p_ack_is_mark_r10: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (hs_ack == mark));

  p_ack_exact_count_r4: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_ack) |-> (cnt == CNT_FULL));

  p_hs_after_drain_r9: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (buf_empty && !wr_busy));

endmodule

// File: rtl/bulk_out_rx_seq.sv
module bulk_out_rx_seq
  import bor_pkg::*;
#(
  parameter int MAX_PKT   = 64,
  parameter int DW        = 8,
  parameter int BUF_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rx_err,
  input  logic          fifo_wr_rdy,
  input  logic          fifo_ovr,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wr_data,
  output logic          fifo_mark,
  output logic          fifo_rewind,
  output logic          hs_valid,
  output logic          hs_ack
);

  logic          push_en;
  logic          pop;
  logic [DW-1:0] head;
  logic          buf_empty;
  logic          buf_ovr;
  logic          ovr_hit;
  bor_state_t    st;

  bor_rx_buffer #(
    .DW    (DW),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (push_en),
    .din       (rx_data),
    .drain_rdy (fifo_wr_rdy),
    .pop       (pop),
    .dout      (head),
    .empty     (buf_empty),
    .overrun   (buf_ovr)
  );

  bor_wr_stage #(
    .DW (DW)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .take      (pop),
    .take_data (head),
    .wr_rdy    (fifo_wr_rdy),
    .ovr_in    (fifo_ovr),
    .wr_en     (fifo_wr_en),
    .wr_data   (fifo_wr_data),
    .ovr_hit   (ovr_hit)
  );

  bor_ctrl #(
    .MAX_PKT (MAX_PKT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_eop    (rx_eop),
    .rx_err    (rx_err),
    .buf_empty (buf_empty),
    .buf_ovr   (buf_ovr),
    .wr_busy   (fifo_wr_en),
    .ovr_hit   (ovr_hit),
    .push_en   (push_en),
    .st        (st),
    .hs_valid  (hs_valid),
    .hs_ack    (hs_ack),
    .mark      (fifo_mark),
    .rewind    (fifo_rewind)
  );

  p_idle_no_write_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !fifo_wr_en);

  p_hs_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> !fifo_wr_en);

endmodule

// File: tb/bulk_out_rx_seq_tb.sv
module bulk_out_rx_seq_tb;

  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_eop = 1'b0;
  logic       rx_err = 1'b0;
  logic       fifo_wr_rdy = 1'b1;
  logic       fifo_ovr = 1'b0;
  logic       fifo_wr_en;
  logic [7:0] fifo_wr_data;
  logic       fifo_mark;
  logic       fifo_rewind;
  logic       hs_valid;
  logic       hs_ack;

  int errors = 0;
  int checks = 0;

  int         wr_cnt;
  logic [7:0] wr_log [0:127];
  int         hs_cnt;
  int         mark_cnt;
  int         rew_cnt;
  logic       last_ack;
  int         rdy_viol;
  bit         mon_on = 1'b0;

  always #10 clk = ~clk;

  bulk_out_rx_seq #(.MAX_PKT(MAXP)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_eop       (rx_eop),
    .rx_err       (rx_err),
    .fifo_wr_rdy  (fifo_wr_rdy),
    .fifo_ovr     (fifo_ovr),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .fifo_mark    (fifo_mark),
    .fifo_rewind  (fifo_rewind),
    .hs_valid     (hs_valid),
    .hs_ack       (hs_ack)
  );

  // sample 5 ns after each rising edge; inputs change only on falling edges
  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      if (fifo_wr_en) begin
        if (wr_cnt < 128) wr_log[wr_cnt] = fifo_wr_data;
        wr_cnt++;
        if (!fifo_wr_rdy) rdy_viol++;
      end
      if (hs_valid) begin
        hs_cnt++;
        last_ack = hs_ack;
      end
      if (fifo_mark) mark_cnt++;
      if (fifo_rewind) rew_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_cnt = 0; hs_cnt = 0; mark_cnt = 0; rew_cnt = 0; rdy_viol = 0;
    last_ack = 1'b0;
  endtask

  // send n bytes base+i; rdy low for indices in [st_lo, st_hi]
  task automatic send(input int n, input int base, input int err_at,
                      input int st_lo, input int st_hi, input int ovr_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid    = 1'b1;
      rx_data     = 8'(base + i);
      rx_err      = (i == err_at);
      fifo_ovr    = (i == ovr_at);
      fifo_wr_rdy = !((i >= st_lo) && (i <= st_hi));
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_err   = 1'b0;
    fifo_ovr = 1'b0;
  endtask

  task automatic send_eop();
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
  endtask

  task automatic expect_hs(input string req, input bit exp_ack, input int exp_wr,
                           input int base, input int skip);
    int mism;
    for (int c = 0; c < 300 && hs_cnt == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(hs_cnt == 1, req, "handshake count", hs_cnt, 1);
    check(last_ack == exp_ack, req, "hs_ack", int'(last_ack), int'(exp_ack));
    check(mark_cnt == (exp_ack ? 1 : 0), req, "mark pulses", mark_cnt, exp_ack ? 1 : 0);
    check(rew_cnt == (exp_ack ? 0 : 1), req, "rewind pulses", rew_cnt, exp_ack ? 0 : 1);
    check(wr_cnt == exp_wr, req, "write count", wr_cnt, exp_wr);
    mism = 0;
    for (int k = 0; k < exp_wr && k < wr_cnt && k < 128; k++) begin
      if (wr_log[k] != 8'(base + ((skip >= 0 && k >= skip) ? k + 1 : k))) mism++;
    end
    check(mism == 0, req, "write order mismatches", mism, 0);
    check(rdy_viol == 0, "R3", "writes without ready", rdy_viol, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!fifo_wr_en, "R1", "fifo_wr_en after reset", int'(fifo_wr_en), 0);
    check(!hs_valid, "R1", "hs_valid after reset", int'(hs_valid), 0);
    check(!hs_ack, "R1", "hs_ack after reset", int'(hs_ack), 0);
    check(!fifo_mark && !fifo_rewind, "R1", "mark|rewind after reset",
          int'(fifo_mark | fifo_rewind), 0);
  endtask

  task automatic t_good(input int base, input string req);
    clear_mon();
    send(MAXP, base, -1, -1, -1, -1);
    send_eop();
    expect_hs(req, 1'b1, MAXP, base, -1);
  endtask

  task automatic t_len(input int n, input int base);
    clear_mon();
    if (n > 0) send(n, base, -1, -1, -1, -1);
    else @(negedge clk);
    send_eop();
    expect_hs("R5", 1'b0, n, base, -1);
  endtask

  task automatic t_rx_err();
    clear_mon();
    send(MAXP, 8'h40, 5, -1, -1, -1);
    send_eop();
    expect_hs("R6", 1'b0, MAXP, 8'h40, -1);
  endtask

  task automatic t_err_at_eop();
    clear_mon();
    send(MAXP, 8'h50, -1, -1, -1, -1);
    rx_err = 1'b1;
    send_eop();
    rx_err = 1'b0;
    expect_hs("R6", 1'b0, MAXP, 8'h50, -1);
  endtask

  task automatic t_stall();
    clear_mon();
    send(MAXP, 8'h60, -1, 0, 1, -1);
    send_eop();
    expect_hs("R3", 1'b1, MAXP, 8'h60, -1);
  endtask

  task automatic t_buf_ovr();
    clear_mon();
    send(MAXP, 8'h70, -1, 0, 2, -1);
    send_eop();
    expect_hs("R7", 1'b0, MAXP - 1, 8'h70, 2);
  endtask

  task automatic t_fifo_ovr();
    clear_mon();
    send(MAXP, 8'h90, -1, -1, -1, 20);
    send_eop();
    expect_hs("R8", 1'b0, MAXP, 8'h90, -1);
  endtask

  task automatic t_hold_and_ignore();
    clear_mon();
    send(MAXP, 8'hA0, -1, MAXP - 1, MAXP - 1, -1);
    send_eop();
    for (int j = 0; j < 3; j++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(8'hF0 + j);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(hs_cnt == 0, "R9", "handshake while drain held", hs_cnt, 0);
    check(wr_cnt == MAXP - 2, "R9", "writes while held", wr_cnt, MAXP - 2);
    fifo_wr_rdy = 1'b1;
    expect_hs("R12", 1'b1, MAXP, 8'hA0, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    mon_on = 1'b1;
    clear_mon();
    t_good(8'h00, "R4");   // R2 order also checked here
    t_len(10, 8'h10);
    t_len(MAXP + 1, 8'h20);
    t_len(0, 8'h00);
    t_rx_err();
    t_good(8'h30, "R11");
    t_err_at_eop();
    t_stall();
    t_buf_ovr();
    t_good(8'h80, "R11");
    t_fifo_ovr();
    t_hold_and_ignore();
    t_good(8'hB0, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule